// File: doc/BRIEF.md
# Runtime Programmable Pad Router

This block connects the output side of a set of on-chip peripherals to a smaller set of shared bidirectional pads, and connects the pad inputs back to the peripheral input side. The connection is not fixed in silicon. A set of select registers decides it, and software writes those registers through a simple write/read port. Each pad has one output select. That select picks a peripheral output, a constant low, a constant high, or a floating (undriven) state. Each peripheral input has one input select, which picks a pad, a constant low or a constant high.

A single select value per pad chooses both the data and the output enable. The chosen peripheral therefore controls the pad's direction cycle by cycle. Software normally sets up the routing once at start-up. It then sets the lock bit, which freezes every select register until the next reset. All data paths are combinational from the registered selects. Only the configuration is clocked.

Top module: `pad_route_mux`

## Requirements
- R1: After reset every pad output select reads back 2 (floating), so every pad has enable 0 and data 0. Every peripheral input select reads back 0, so every peripheral input is 0. The lock reads back 0.
- R2: Output select code 0 drives the pad data to 0 with enable 1. Code 1 drives data 1 with enable 1. Code 2 drives data 0 with enable 0.
- R3: Output select code 3+k, for k from 0 to N_POUT-1, copies peripheral output k to the pad data and peripheral enable k to the pad enable.
- R4: Input select code 0 drives the peripheral input to 0. Code 1 drives it to 1. Code 2+j, for j from 0 to N_PAD-1, copies pad input j.
- R5: An output select code of 3+N_POUT or above behaves like code 2 (data 0, enable 0). An input select code of 2+N_PAD or above behaves like code 0.
- R6: The register map is as follows. Address 0 holds the lock in bit 0. Address 1+i holds the input select of peripheral input i. Address 1+N_PIN+p holds the output select of pad p. Values are right-aligned in the data word, and the upper bits read as 0. A write to any other address changes nothing, and a read from any other address returns 0.
- R7: A write presented on a clock edge changes the outputs only after that edge. The routing outputs follow the select registers and the peripheral and pad inputs with no further clock delay.
- R8: Writing 1 to bit 0 at address 0 sets the lock. While the lock is set, writes to every select register are ignored. Writing 0 to address 0 does not clear the lock; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address for both reads and writes |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Read data for cfg_addr_i (combinational) |
| periph_out_i | input | N_POUT | Output data from the peripherals |
| periph_oe_i | input | N_POUT | Output enables from the peripherals |
| periph_in_o | output | N_PIN | Input data delivered to the peripherals |
| pad_out_o | output | N_PAD | Output data to the pads |
| pad_oe_o | output | N_PAD | Output enables to the pads |
| pad_in_i | input | N_PAD | Input data from the pads |

## Verification
The routing properties sample the combinational outputs on the rising clock edge. They assume that the peripheral and pad inputs are settled at that edge, so the bench changes every input on the falling edge. The freeze properties assume that a select register can change only through an accepted write. They also assume that DATA_W is at least as wide as the widest select code, so that truncating the written value is the only alteration. The stimulus keeps its write values within the select width and confines writes to single-cycle strobes driven between edges.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  // Output select codes (per pad)
  localparam int unsigned OSEL_LOW         = 0;
  localparam int unsigned OSEL_HIGH        = 1;
  localparam int unsigned OSEL_FLOAT       = 2;
  localparam int unsigned OSEL_PERIPH_BASE = 3;

  // Input select codes (per peripheral input)
  localparam int unsigned ISEL_LOW         = 0;
  localparam int unsigned ISEL_HIGH        = 1;
  localparam int unsigned ISEL_PAD_BASE    = 2;

  // Register map anchors
  localparam int unsigned LOCK_ADDR        = 0;
  localparam int unsigned IN_SEL_BASE      = 1;

  typedef struct packed {
    logic data;
    logic en;
  } drive_t;

  function automatic int unsigned osel_width(input int unsigned n_src);
    return $clog2(n_src + OSEL_PERIPH_BASE);
  endfunction

  function automatic int unsigned isel_width(input int unsigned n_pad);
    return $clog2(n_pad + ISEL_PAD_BASE);
  endfunction

  function automatic int unsigned out_sel_base(input int unsigned n_in);
    return IN_SEL_BASE + n_in;
  endfunction

endpackage

// File: rtl/pmx_cfg_regs.sv
module pmx_cfg_regs
  import pmx_pkg::*;
#(
  parameter int unsigned N_PIN  = 16,
  parameter int unsigned N_PAD  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ISW    = 4,
  parameter int unsigned OSW    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   lock_o,
  output logic                   wr_blocked_o,
  output logic [N_PIN*ISW-1:0]   isel_o,
  output logic [N_PAD*OSW-1:0]   osel_o
);

  localparam int unsigned OUT_BASE = out_sel_base(N_PIN);
  localparam int unsigned END_ADDR = OUT_BASE + N_PAD;

  logic [ISW-1:0] isel_q [N_PIN];
  logic [OSW-1:0] osel_q [N_PAD];
  logic           lock_q;

  int unsigned addr_u, in_idx, out_idx;
  logic        hit_lock, hit_in, hit_out, wr_accept;
  logic        unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    addr_u   = 32'(addr_i);
    hit_lock = (addr_u == LOCK_ADDR);
    hit_in   = (addr_u >= IN_SEL_BASE) && (addr_u < OUT_BASE);
    hit_out  = (addr_u >= OUT_BASE) && (addr_u < END_ADDR);
    in_idx   = addr_u - IN_SEL_BASE;
    out_idx  = addr_u - OUT_BASE;
  end

  // A write lands only when unlocked and aimed at a mapped register
  assign wr_accept    = we_i && !lock_q && (hit_lock || hit_in || hit_out);
  assign wr_blocked_o = we_i && lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      for (int i = 0; i < int'(N_PIN); i++) isel_q[i] <= ISW'(ISEL_LOW);
      for (int p = 0; p < int'(N_PAD); p++) osel_q[p] <= OSW'(OSEL_FLOAT);
    end else if (wr_accept) begin
      if (hit_lock) lock_q <= wdata_i[0];
      for (int i = 0; i < int'(N_PIN); i++)
        if (hit_in && in_idx == 32'(i)) isel_q[i] <= wdata_i[ISW-1:0];
      for (int p = 0; p < int'(N_PAD); p++)
        if (hit_out && out_idx == 32'(p)) osel_q[p] <= wdata_i[OSW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_lock) rdata_o[0] = lock_q;
    for (int i = 0; i < int'(N_PIN); i++)
      if (hit_in && in_idx == 32'(i)) rdata_o[ISW-1:0] = isel_q[i];
    for (int p = 0; p < int'(N_PAD); p++)
      if (hit_out && out_idx == 32'(p)) rdata_o[OSW-1:0] = osel_q[p];
  end

  assign lock_o = lock_q;

  for (genvar gi = 0; gi < N_PIN; gi++) begin : g_iflat
    assign isel_o[gi*ISW +: ISW] = isel_q[gi];
  end
  for (genvar gp = 0; gp < N_PAD; gp++) begin : g_oflat
    assign osel_o[gp*OSW +: OSW] = osel_q[gp];
  end

endmodule

// File: rtl/pmx_pad_drive.sv
module pmx_pad_drive
  import pmx_pkg::*;
#(
  parameter int unsigned N_POUT = 16,
  parameter int unsigned OSW    = 5
) (
  input  logic [OSW-1:0]    sel_i,
  input  logic [N_POUT-1:0] periph_out_i,
  input  logic [N_POUT-1:0] periph_oe_i,
  output logic              pad_out_o,
  output logic              pad_oe_o
);

  // One select value chooses both data and enable for the pad
  function automatic drive_t pick_drive(input logic [OSW-1:0]    sel,
                                        input logic [N_POUT-1:0] d,
                                        input logic [N_POUT-1:0] e);
    drive_t      r;
    int unsigned s;
    s = 32'(sel);
    r = '{data: 1'b0, en: 1'b0};
    if (s == OSEL_LOW)  r = '{data: 1'b0, en: 1'b1};
    if (s == OSEL_HIGH) r = '{data: 1'b1, en: 1'b1};
    for (int k = 0; k < int'(N_POUT); k++)
      if (s == OSEL_PERIPH_BASE + 32'(k)) r = '{data: d[k], en: e[k]};
    return r;
  endfunction

  drive_t drv;
  assign drv       = pick_drive(sel_i, periph_out_i, periph_oe_i);
  assign pad_out_o = drv.data;
  assign pad_oe_o  = drv.en;

endmodule

// File: rtl/pmx_periph_sample.sv
module pmx_periph_sample
  import pmx_pkg::*;
#(
  parameter int unsigned N_PAD = 8,
  parameter int unsigned ISW   = 4
) (
  input  logic [ISW-1:0]   sel_i,
  input  logic [N_PAD-1:0] pad_in_i,
  output logic             periph_in_o
);

  function automatic logic pick_input(input logic [ISW-1:0]   sel,
                                      input logic [N_PAD-1:0] pads);
    logic        r;
    int unsigned s;
    s = 32'(sel);
    r = 1'b0;
    if (s == ISEL_HIGH) r = 1'b1;
    for (int j = 0; j < int'(N_PAD); j++)
      if (s == ISEL_PAD_BASE + 32'(j)) r = pads[j];
    return r;
  endfunction

  assign periph_in_o = pick_input(sel_i, pad_in_i);

endmodule

// File: rtl/pad_route_mux.sv
module pad_route_mux
  import pmx_pkg::*;
#(
  parameter int unsigned N_POUT = 16,
  parameter int unsigned N_PIN  = 16,
  parameter int unsigned N_PAD  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic [N_POUT-1:0] periph_out_i,
  input  logic [N_POUT-1:0] periph_oe_i,
  output logic [N_PIN-1:0]  periph_in_o,
  output logic [N_PAD-1:0]  pad_out_o,
  output logic [N_PAD-1:0]  pad_oe_o,
  input  logic [N_PAD-1:0]  pad_in_i
);

  localparam int unsigned OSW = osel_width(N_POUT);
  localparam int unsigned ISW = isel_width(N_PAD);

  // Named internal events for the bound checker
  logic                 lock_w;
  logic                 wr_blocked_w;
  logic [N_PIN*ISW-1:0] isel_flat;
  logic [N_PAD*OSW-1:0] osel_flat;

  pmx_cfg_regs #(
    .N_PIN (N_PIN),
    .N_PAD (N_PAD),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ISW   (ISW),
    .OSW   (OSW)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .lock_o      (lock_w),
    .wr_blocked_o(wr_blocked_w),
    .isel_o      (isel_flat),
    .osel_o      (osel_flat)
  );

  for (genvar gp = 0; gp < N_PAD; gp++) begin : g_pad
    pmx_pad_drive #(
      .N_POUT(N_POUT),
      .OSW   (OSW)
    ) u_drive (
      .sel_i       (osel_flat[gp*OSW +: OSW]),
      .periph_out_i(periph_out_i),
      .periph_oe_i (periph_oe_i),
      .pad_out_o   (pad_out_o[gp]),
      .pad_oe_o    (pad_oe_o[gp])
    );
  end

  for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pin
    pmx_periph_sample #(
      .N_PAD(N_PAD),
      .ISW  (ISW)
    ) u_sample (
      .sel_i      (isel_flat[gi*ISW +: ISW]),
      .pad_in_i   (pad_in_i),
      .periph_in_o(periph_in_o[gi])
    );
  end

endmodule

// File: rtl/pad_route_mux_chk.sv
module pad_route_mux_chk
  import pmx_pkg::*;
#(
  parameter int unsigned N_POUT = 16,
  parameter int unsigned N_PIN  = 16,
  parameter int unsigned N_PAD  = 8
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   lock_i,
  input logic                                   wr_blocked_i,
  input logic [N_PIN*isel_width(N_PAD)-1:0]     isel_flat_i,
  input logic [N_PAD*osel_width(N_POUT)-1:0]    osel_flat_i,
  input logic [N_POUT-1:0]                      periph_out_i,
  input logic [N_POUT-1:0]                      periph_oe_i,
  input logic [N_PIN-1:0]                       periph_in_i,
  input logic [N_PAD-1:0]                       pad_out_i,
  input logic [N_PAD-1:0]                       pad_oe_i,
  input logic [N_PAD-1:0]                       pad_in_i
);

  localparam int unsigned OSW = osel_width(N_POUT);
  localparam int unsigned ISW = isel_width(N_PAD);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i); // R8

  AST_LOCK_FREEZES_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(isel_flat_i) && $stable(osel_flat_i))); // R8

  AST_BLOCKED_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_blocked_i |=> $stable(osel_flat_i)); // R8

  for (genvar gp = 0; gp < N_PAD; gp++) begin : g_pad_chk
    AST_FLOAT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(osel_flat_i[gp*OSW +: OSW]) == OSEL_FLOAT) |-> (!pad_oe_i[gp] && !pad_out_i[gp])); // R2

    AST_CONST_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(osel_flat_i[gp*OSW +: OSW]) < OSEL_FLOAT)
        |-> (pad_oe_i[gp] && (pad_out_i[gp] == osel_flat_i[gp*OSW]))); // R2

    AST_OUT_RANGE_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(osel_flat_i[gp*OSW +: OSW]) >= OSEL_PERIPH_BASE + N_POUT)
        |-> (!pad_oe_i[gp] && !pad_out_i[gp])); // R5

    for (genvar gk = 0; gk < N_POUT; gk++) begin : g_src
      AST_PAD_FOLLOWS_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(osel_flat_i[gp*OSW +: OSW]) == OSEL_PERIPH_BASE + 32'(gk))
          |-> ((pad_out_i[gp] == periph_out_i[gk]) && (pad_oe_i[gp] == periph_oe_i[gk]))); // R3
    end
  end

  for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pin_chk
    AST_IN_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(isel_flat_i[gi*ISW +: ISW]) < ISEL_PAD_BASE)
        |-> (periph_in_i[gi] == isel_flat_i[gi*ISW])); // R4

    AST_IN_RANGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(isel_flat_i[gi*ISW +: ISW]) >= ISEL_PAD_BASE + N_PAD) |-> !periph_in_i[gi]); // R5

    for (genvar gj = 0; gj < N_PAD; gj++) begin : g_src
      AST_IN_FOLLOWS_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(isel_flat_i[gi*ISW +: ISW]) == ISEL_PAD_BASE + 32'(gj))
          |-> (periph_in_i[gi] == pad_in_i[gj])); // R4
    end
  end

endmodule

bind pad_route_mux pad_route_mux_chk #(
  .N_POUT(N_POUT),
  .N_PIN (N_PIN),
  .N_PAD (N_PAD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_i      (lock_w),
  .wr_blocked_i(wr_blocked_w),
  .isel_flat_i (isel_flat),
  .osel_flat_i (osel_flat),
  .periph_out_i(periph_out_i),
  .periph_oe_i (periph_oe_i),
  .periph_in_i (periph_in_o),
  .pad_out_i   (pad_out_o),
  .pad_oe_i    (pad_oe_o),
  .pad_in_i    (pad_in_i)
);

// File: tb/pad_route_mux_test.sv
`timescale 1ns/1ps
module pad_route_mux_test;

  localparam int NPO = 16, NPI = 16, NPD = 8;
  localparam logic [7:0] A_LOCK = 8'd0;
  localparam int IN_BASE = 1;
  localparam int OUT_BASE = 1 + NPI;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pout = '0;
  logic [15:0] poe = '0;
  logic [15:0] pin;
  logic [7:0]  pad_out, pad_oe;
  logic [7:0]  pad_in = '0;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  pad_route_mux uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .periph_out_i(pout), .periph_oe_i(poe), .periph_in_o(pin),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_in_i(pad_in)
  );

  // Pad 3 stimulus table: {sel[7:0], pout[15:0], poe[15:0], exp_data, exp_en}
  localparam int NV = 10;
  localparam logic [41:0] OUT_VEC [NV] = '{
    {8'd0,  16'hFFFF, 16'h0000, 1'b0, 1'b1},
    {8'd1,  16'h0000, 16'h0000, 1'b1, 1'b1},
    {8'd2,  16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    {8'd3,  16'h0001, 16'h0000, 1'b1, 1'b0},
    {8'd8,  16'h0020, 16'h0020, 1'b1, 1'b1},
    {8'd8,  16'hFFDF, 16'hFFDF, 1'b0, 1'b0},
    {8'd18, 16'h8000, 16'h0000, 1'b1, 1'b0},
    {8'd18, 16'h7FFF, 16'h8000, 1'b0, 1'b1},
    {8'd19, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    {8'd31, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, 32'(rdata), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [41:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state with all sources driven high
    pout = 16'hFFFF; poe = 16'hFFFF; pad_in = 8'hFF;
    #1;
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 periph_in", 32'(pin), 32'h0);
    cfg_read_check("R1 lock", A_LOCK, 8'd0);
    cfg_read_check("R1 osel pad0", 8'(OUT_BASE), 8'd2);
    cfg_read_check("R1 isel in0", 8'(IN_BASE), 8'd0);

    // Table walk on pad 3: R2 constants, R3 peripheral routing, R5 out of range
    for (int i = 0; i < NV; i++) begin
      v = OUT_VEC[i];
      pout = v[33:18]; poe = v[17:2];
      cfg_write(8'(OUT_BASE + 3), v[41:34]);
      #1;
      if (v[41:34] < 8'd3) begin
        check("R2 pad3 data", 32'(pad_out[3]), 32'(v[1]));
        check("R2 pad3 en", 32'(pad_oe[3]), 32'(v[0]));
      end else if (v[41:34] < 8'd19) begin
        check("R3 pad3 data", 32'(pad_out[3]), 32'(v[1]));
        check("R3 pad3 en", 32'(pad_oe[3]), 32'(v[0]));
      end else begin
        check("R5 pad3 data", 32'(pad_out[3]), 32'(v[1]));
        check("R5 pad3 en", 32'(pad_oe[3]), 32'(v[0]));
      end
      check("R6 other pads idle", 32'(pad_oe & 8'hF7), 32'h0);
    end

    // R7: write visible only after the capturing edge
    pout = 16'h0004; poe = 16'h0004;
    @(negedge clk);
    we = 1'b1; addr = 8'(OUT_BASE + 3); wdata = 8'd5;
    #1 check("R7 before edge", 32'(pad_oe[3]), 32'h0);
    @(negedge clk);
    we = 1'b0;
    #1 check("R7 after edge en", 32'(pad_oe[3]), 32'h1);
    check("R7 after edge data", 32'(pad_out[3]), 32'h1);

    // R4 input selection on peripheral input 2, pad_in = 1010_0101
    pad_in = 8'hA5;
    cfg_write(8'(IN_BASE + 2), 8'd9);  #1 check("R4 pad7", 32'(pin[2]), 32'h1);
    cfg_write(8'(IN_BASE + 2), 8'd3);  #1 check("R4 pad1", 32'(pin[2]), 32'h0);
    cfg_write(8'(IN_BASE + 2), 8'd2);  #1 check("R4 pad0", 32'(pin[2]), 32'h1);
    pad_in = 8'h00;
    cfg_write(8'(IN_BASE + 2), 8'd1);  #1 check("R4 const1", 32'(pin[2]), 32'h1);
    pad_in = 8'hFF;
    cfg_write(8'(IN_BASE + 2), 8'd0);  #1 check("R4 const0", 32'(pin[2]), 32'h0);
    cfg_write(8'(IN_BASE + 2), 8'd10); #1 check("R5 in sel 10", 32'(pin[2]), 32'h0);
    cfg_write(8'(IN_BASE + 2), 8'd15); #1 check("R5 in sel 15", 32'(pin[2]), 32'h0);
    check("R4 other inputs", 32'(pin & 16'hFFFB), 32'h0);

    // R6 register map and unmapped addresses
    cfg_write(8'(IN_BASE + 4), 8'd9);
    cfg_read_check("R6 isel in4", 8'(IN_BASE + 4), 8'd9);
    cfg_write(8'(OUT_BASE + 2), 8'd18);
    cfg_read_check("R6 osel pad2", 8'(OUT_BASE + 2), 8'd18);
    cfg_read_check("R6 osel pad3", 8'(OUT_BASE + 3), 8'd5);
    cfg_write(8'd25, 8'hFF);
    cfg_read_check("R6 unmapped read", 8'd25, 8'd0);
    cfg_read_check("R6 lock untouched", A_LOCK, 8'd0);
    #1 check("R6 pad3 untouched", 32'(pad_oe[3]), 32'h1);
    cfg_write(8'd200, 8'hFF);
    cfg_read_check("R6 lock untouched 200", A_LOCK, 8'd0);

    // R8 lock
    pout = 16'h0002; poe = 16'h0002;
    cfg_write(8'(OUT_BASE + 1), 8'd4);
    #1 check("R3 pad1 data", 32'(pad_out[1]), 32'h1);
    cfg_write(A_LOCK, 8'd1);
    cfg_read_check("R8 lock set", A_LOCK, 8'd1);
    cfg_write(8'(OUT_BASE + 1), 8'd1);
    pout = 16'h0000;
    #1 check("R8 pad1 still periph", 32'(pad_out[1]), 32'h0);
    check("R8 pad1 en", 32'(pad_oe[1]), 32'h1);
    cfg_read_check("R8 osel frozen", 8'(OUT_BASE + 1), 8'd4);
    cfg_write(8'(IN_BASE + 2), 8'd1);
    cfg_read_check("R8 isel frozen", 8'(IN_BASE + 2), 8'd15);
    #1 check("R8 input frozen", 32'(pin[2]), 32'h0);
    cfg_write(A_LOCK, 8'd0);
    cfg_read_check("R8 lock not clearable", A_LOCK, 8'd1);

    // R1 reset clears lock and map
    do_reset();
    pout = 16'hFFFF; poe = 16'hFFFF;
    cfg_read_check("R1 lock after reset", A_LOCK, 8'd0);
    #1 check("R1 pads float after reset", 32'(pad_oe), 32'h0);
    check("R1 inputs low after reset", 32'(pin), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule